// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus: an active-high address-latch strobe and an active-low program-fetch read strobe. It also selects the byte that the upper address port drives. It runs from the oscillator clock. Each machine cycle is `CYC_CLKS` oscillator clocks long (12 by default) and is split into two equal halves. Each half can carry one address-latch pulse followed by one fetch-strobe pulse.

At the clock edge that starts a machine cycle, the block captures a description of that cycle from the sequencer and holds it for the whole cycle. The description says whether code runs from external memory, whether the cycle is an external data transfer (and whether it uses a full-width or a byte-wide address), whether it is a table read from program memory, and whether software has muted the address-latch strobe. The strobes are decoded from the cycle phase and this held description. Data transfers take one latch pulse and both fetch pulses away. The mute bit parks the latch line high, except in cycles that need the bus. External execution overrides the mute bit.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst` is high, `ale_o` is 0, `psen_n_o` is 1 and `hi_o` is 0.
- R2: Phase 0 is the clock after the capture edge, and the phase counts 0 to 11 from there. In a cycle that is not a data transfer and is not muted, `ale_o` is 1 in phases 0, 1, 6 and 7 and 0 in every other phase. This gives two pulses of two clocks each per machine cycle.
- R3: In an external data cycle (`xd_cycle`=1), the pulse in phases 0 and 1 is kept and the pulse in phases 6 and 7 is dropped.
- R4: When `ext_run` or `tbl_cycle` is 1 and `xd_cycle` is 0, `psen_n_o` is 0 in phases 3, 4, 5, 9, 10 and 11 and 1 in every other phase.
- R5: In an external data cycle, `psen_n_o` stays 1 for the whole machine cycle, so both fetch pulses are omitted.
- R6: When `ext_run`, `tbl_cycle` and `xd_cycle` are all 0, `psen_n_o` stays 1 for the whole machine cycle.
- R7: `ale_o`=1 and `psen_n_o`=0 never occur in the same clock.
- R8: When `ale_mute`=1 and `ext_run`, `xd_cycle` and `tbl_cycle` are all 0, `ale_o` stays 1 for the whole machine cycle.
- R9: When `ale_mute`=1 and the cycle is a data or table cycle (with `ext_run`=0), `ale_o` pulses exactly as in R2 and R3.
- R10: When `ext_run`=1, `ale_mute` has no effect on `ale_o`.
- R11: `hi_o` equals `hi_reg` in a data cycle with `xd_wide`=0. In every other cycle it equals `addr[15:8]`.
- R12: All inputs are sampled only at the capture edge (the edge where phase 11 becomes phase 0). A change at any other time leaves all outputs unchanged until the next machine cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_run | input | 1 | Code is being fetched from external memory |
| xd_cycle | input | 1 | This machine cycle is an external data transfer |
| xd_wide | input | 1 | The data transfer uses a full 16-bit address |
| tbl_cycle | input | 1 | This machine cycle is a program-memory table read |
| ale_mute | input | 1 | Software address-latch suppress bit |
| addr | input | 16 | Bus address for this cycle |
| hi_reg | input | 8 | Upper port register contents |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-fetch read strobe, active low |
| hi_o | output | 8 | Byte driven on the upper address port |

## Verification
The hardest situation to reach is a change of the cycle description part-way through a machine cycle. The outputs must ignore it, and many wrong designs still look right while the inputs happen to stay still. The stimulus therefore draws a new random description, address and port value right after phase 5 of every cycle, and keeps checking the remaining phases against the description captured at the cycle start. Directed cycles cover the mute and external-execution combinations, because random draws rarely hit them all in a row.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
   typedef struct packed {
      logic run;
      logic dat;
      logic wide;
      logic tbl;
      logic mute;
   } xbs_desc_t;
endpackage

// File: rtl/xbs_phase_ctr.sv
module xbs_phase_ctr #(
   parameter int CYC_CLKS = 12,
   localparam int PW = $clog2(CYC_CLKS)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] phase,
   output logic          start
);
   localparam logic [PW-1:0] LAST = PW'(CYC_CLKS - 1);

   // start marks the edge that enters phase 0 (capture edge)
   assign start = (phase == LAST);

   always_ff @(posedge clk) begin
      if (rst)        phase <= LAST;
      else if (start) phase <= '0;
      else            phase <= phase + 1'b1;
   end

   assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
      phase <= LAST);
   assert_wrap_R12: assert property (@(posedge clk) disable iff (rst)
      start |=> (phase == '0));
endmodule

// File: rtl/xbs_strobe_dec.sv
module xbs_strobe_dec
   import xbs_pkg::*;
#(
   parameter int CYC_CLKS  = 12,
   parameter int ALE_CLKS  = 2,
   parameter int PSEN_CLKS = 3,
   localparam int PW   = $clog2(CYC_CLKS),
   localparam int HALF = CYC_CLKS / 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] phase,
   input  xbs_desc_t     desc,
   output logic          ale_o,
   output logic          psen_n_o
);
   logic [1:0] ale_win;
   logic [1:0] ps_win;

   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [PW-1:0] BASE = PW'(h * HALF);
      localparam logic [PW-1:0] A_END = PW'(ALE_CLKS);
      localparam logic [PW-1:0] P_BEG = PW'(HALF - PSEN_CLKS);
      localparam logic [PW-1:0] P_END = PW'(HALF);
      logic [PW-1:0] off;
      always_comb begin
         off        = phase - BASE;
         ale_win[h] = (off < A_END);
         ps_win[h]  = (off >= P_BEG) && (off < P_END);
      end
   end

   logic quiet;
   logic fetch_on;

   always_comb begin
      quiet    = desc.mute & ~desc.run & ~desc.dat & ~desc.tbl;
      fetch_on = (desc.run | desc.tbl) & ~desc.dat;
      ale_o    = quiet | ale_win[0] | (ale_win[1] & ~desc.dat);
      psen_n_o = ~(fetch_on & (|ps_win));
   end

   assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
      !(ale_o && !psen_n_o));
   assert_data_no_fetch_R5: assert property (@(posedge clk) disable iff (rst)
      desc.dat |-> psen_n_o);
   assert_idle_fetch_R6: assert property (@(posedge clk) disable iff (rst)
      (!desc.run && !desc.tbl) |-> psen_n_o);
   assert_data_drop_R3: assert property (@(posedge clk) disable iff (rst)
      (desc.dat && phase >= PW'(HALF)) |-> !ale_o);
endmodule

// File: rtl/xbs_hi_mux.sv
module xbs_hi_mux #(
   parameter int AW = 16,
   localparam int HW = AW / 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          dat,
   input  logic          wide,
   input  logic [AW-1:0] addr,
   input  logic [HW-1:0] hi_reg,
   output logic [HW-1:0] hi_o
);
   always_ff @(posedge clk) begin
      if (rst)        hi_o <= '0;
      else if (start) hi_o <= (dat && !wide) ? hi_reg : addr[AW-1:HW];
   end

   assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
      !start |=> $stable(hi_o));
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
   import xbs_pkg::*;
#(
   parameter int CYC_CLKS  = 12,
   parameter int ALE_CLKS  = 2,
   parameter int PSEN_CLKS = 3,
   parameter int AW        = 16,
   localparam int PW = $clog2(CYC_CLKS),
   localparam int HW = AW / 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ext_run,
   input  logic          xd_cycle,
   input  logic          xd_wide,
   input  logic          tbl_cycle,
   input  logic          ale_mute,
   input  logic [AW-1:0] addr,
   input  logic [HW-1:0] hi_reg,
   output logic          ale_o,
   output logic          psen_n_o,
   output logic [HW-1:0] hi_o
);
   if (CYC_CLKS % 2 != 0) begin : g_chk_even
      $error("CYC_CLKS must be even");
   end
   if (ALE_CLKS < 1 || PSEN_CLKS < 1 || ALE_CLKS + PSEN_CLKS >= CYC_CLKS / 2) begin : g_chk_fit
      $error("strobe widths must leave a gap inside each half cycle");
   end
   if (AW % 2 != 0) begin : g_chk_aw
      $error("AW must be even");
   end

   logic [PW-1:0] phase;
   logic          start;
   xbs_desc_t     desc;

   xbs_phase_ctr #(.CYC_CLKS(CYC_CLKS)) u_ctr (
      .clk(clk), .rst(rst), .phase(phase), .start(start)
   );

   always_ff @(posedge clk) begin
      if (rst) desc <= '0;
      else if (start) begin
         desc.run  <= ext_run;
         desc.dat  <= xd_cycle;
         desc.wide <= xd_wide;
         desc.tbl  <= tbl_cycle;
         desc.mute <= ale_mute;
      end
   end

   xbs_strobe_dec #(.CYC_CLKS(CYC_CLKS), .ALE_CLKS(ALE_CLKS), .PSEN_CLKS(PSEN_CLKS)) u_dec (
      .clk(clk), .rst(rst), .phase(phase), .desc(desc),
      .ale_o(ale_o), .psen_n_o(psen_n_o)
   );

   xbs_hi_mux #(.AW(AW)) u_hi (
      .clk(clk), .rst(rst), .start(start), .dat(xd_cycle), .wide(xd_wide),
      .addr(addr), .hi_reg(hi_reg), .hi_o(hi_o)
   );

   assert_mute_override_R10: assert property (@(posedge clk) disable iff (rst)
      (desc.run && phase == PW'(CYC_CLKS - 1)) |-> !ale_o);
   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (psen_n_o && hi_o == '0));
endmodule

// File: tb/sim_xbus_strobe_gen.sv
`timescale 1ns/1ps
module sim_xbus_strobe_gen;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ext_run = 0, xd_cycle = 0, xd_wide = 0, tbl_cycle = 0, ale_mute = 0;
   logic [15:0] addr = '0;
   logic [7:0]  hi_reg = '0;
   logic ale_o, psen_n_o;
   logic [7:0] hi_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xbus_strobe_gen u0 (
      .clk(clk), .rst(rst), .ext_run(ext_run), .xd_cycle(xd_cycle),
      .xd_wide(xd_wide), .tbl_cycle(tbl_cycle), .ale_mute(ale_mute),
      .addr(addr), .hi_reg(hi_reg), .ale_o(ale_o), .psen_n_o(psen_n_o), .hi_o(hi_o)
   );

   function automatic logic exp_ale(int p, logic r, logic d, logic t, logic m);
      if (m && !r && !d && !t) return 1'b1;
      if (p == 0 || p == 1) return 1'b1;
      if ((p == 6 || p == 7) && !d) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic exp_psen(int p, logic r, logic d, logic t);
      if (d || !(r || t)) return 1'b1;
      if ((p >= 3 && p <= 5) || (p >= 9 && p <= 11)) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_cycle(logic r, logic d, logic w, logic t, logic m,
                            logic [15:0] a, logic [7:0] h);
      logic [7:0] eh;
      string ra, rp;
      ext_run = r; xd_cycle = d; xd_wide = w; tbl_cycle = t; ale_mute = m;
      addr = a; hi_reg = h;
      eh = (d && !w) ? h : a[15:8];
      if (m && !r && !d && !t) ra = "R8";
      else if (m && r)         ra = "R10";
      else if (m)              ra = "R9";
      else if (d)              ra = "R3";
      else                     ra = "R2";
      if (d)             rp = "R5";
      else if (!(r || t)) rp = "R6";
      else               rp = "R4";
      for (int p = 0; p < 12; p++) begin
         @(posedge clk);
         @(negedge clk);
         chk(p > 5 ? "R12" : ra, 16'(ale_o), 16'(exp_ale(p, r, d, t, m)));
         chk(p > 5 ? "R12" : rp, 16'(psen_n_o), 16'(exp_psen(p, r, d, t)));
         chk(p > 5 ? "R12" : "R11", 16'(hi_o), 16'(eh));
         chk("R7", 16'(ale_o && !psen_n_o), 16'd0);
         if (p == 5) begin
            ext_run = 1'($urandom()); xd_cycle = 1'($urandom());
            xd_wide = 1'($urandom()); tbl_cycle = 1'($urandom());
            ale_mute = 1'($urandom());
            addr = 16'($urandom()); hi_reg = 8'($urandom());
         end
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", 16'(ale_o), 16'd0);
      chk("R1", 16'(psen_n_o), 16'd1);
      chk("R1", 16'(hi_o), 16'd0);
      rst = 1'b0;
      // directed corners
      run_cycle(1, 0, 0, 0, 0, 16'hA512, 8'h3C); // R2 R4
      run_cycle(1, 1, 1, 0, 0, 16'hB7F0, 8'h44); // R3 R5 wide
      run_cycle(1, 1, 0, 0, 0, 16'hC001, 8'h99); // R11 narrow
      run_cycle(0, 0, 0, 0, 0, 16'h1234, 8'h00); // R6
      run_cycle(0, 0, 0, 0, 1, 16'h2222, 8'h11); // R8
      run_cycle(0, 0, 0, 1, 1, 16'h3333, 8'h22); // R9 table
      run_cycle(0, 1, 0, 0, 1, 16'h4444, 8'h55); // R9 data
      run_cycle(1, 0, 0, 0, 1, 16'h5555, 8'h66); // R10
      run_cycle(0, 0, 0, 0, 1, 16'hFFFF, 8'hFF); // R8 again
      run_cycle(0, 0, 0, 1, 0, 16'h0100, 8'h01); // R4 table only
      for (int i = 0; i < 300; i++)
         run_cycle(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                   1'($urandom()), 16'($urandom()), 8'($urandom()));
      // reset again mid-stream
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R1", 16'(ale_o), 16'd0);
      chk("R1", 16'(psen_n_o), 16'd1);
      chk("R1", 16'(hi_o), 16'd0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule